// File: doc/BRIEF.md
# Time-Triggered Schedule Organizer

This block runs the message schedule inside each basic cycle of a time-triggered bus node. It keeps a pointer into a trigger table and presents the pointer as a read address. The table holds entries in ascending order of their time marks. In the cycle in which the cycle time equals the mark of the current entry, the entry is decoded. If the current cycle count selects it, the block raises one of four single-cycle strobes: transmit, receive check, reference request or watch timeout. The transmit and receive-check strobes carry the message index of the entry.

An announced gap changes which entries are used. When the last reference message carried its gap flag, the alternate reference and watch entries replace the normal ones. The normal reference entry then marks the point where the gap may begin. In event mode the event pin is sampled at that point: a low level requests the reference message at once, and a high level opens the gap. A falling edge of the pin during a gap requests the reference message early. Without a falling edge, the gap reference entry issues the request.

All outputs are plain registered strobes with no back-pressure. Each strobe is valid for exactly one clock and is not held, so the consumer must take it in that cycle. The trigger table is read combinationally: the address goes out and the entry fields are expected back in the same cycle. The event pin must already be synchronous to `clk`.

Top module: `tt_sched_organizer`

## Requirements
- R1: After reset, all four strobes are low and the table address is 0.
- R2: Function codes are 0 transmit, 1 receive check, 2 reference, 3 watch, 4 gap reference and 5 gap watch. Entries are examined one per clock in table order. An entry acts in the clock when `cycle_time` equals its mark. Its strobe appears one clock later, and at most one of transmit, receive check and watch is high in any clock.
- R3: An entry is selected only when `cycle_cnt` modulo 2^`tm_rep` equals `tm_base`. An entry that is not selected produces no strobe but is still passed over.
- R4: Transmit strobes are suppressed while `sync_ok` is low. Receive-check strobes do not depend on `sync_ok`.
- R5: `ref_req` is raised only when `is_master` is high. `sync_ok` has no effect on it.
- R6: With the gap flag latched low at cycle start, the reference and watch entries act and the gap versions are ignored. With the gap flag latched high, the reverse holds.
- R7: In event mode with the gap flag set, if `evt_pin` is low when the normal reference entry acts, `ref_req` is raised at that point. If `evt_pin` is high, a gap begins instead.
- R8: A falling edge on `evt_pin` while a gap is open raises `ref_req` in the next clock. Falling edges outside a gap are ignored. At most one `ref_req` is issued per basic cycle.
- R9: If no falling edge ends the gap, the gap reference entry raises `ref_req`. The longest gap is therefore the gap reference mark minus the normal reference mark.
- R10: `cycle_start` returns the pointer to entry 0 and latches `rx_gap`. No entry acts in that clock, so a restart before the watch mark prevents the watch timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cycle_time | input | TIME_W | Cycle time in time units |
| cycle_cnt | input | CC_W | Index of the basic cycle in the matrix cycle |
| cycle_start | input | 1 | One-clock pulse when a valid reference message starts a basic cycle |
| sync_ok | input | 1 | Node is synchronized |
| is_master | input | 1 | Node is a potential time master |
| rx_gap | input | 1 | Gap flag of the reference message that starts the cycle |
| event_mode | input | 1 | Event pin decides whether a gap starts |
| evt_pin | input | 1 | Event pin, synchronous |
| tm_addr | output | IDX_W | Trigger table read address |
| tm_mark | input | TIME_W | Time mark of the addressed entry |
| tm_func | input | 3 | Function code of the addressed entry |
| tm_msg | input | MSG_W | Message index of the addressed entry |
| tm_base | input | CC_W | Base cycle of the addressed entry |
| tm_rep | input | REP_W | Log2 of the repeat factor of the addressed entry |
| tx_fire | output | 1 | Transmit strobe |
| tx_msg | output | MSG_W | Message index for the transmit strobe |
| rx_fire | output | 1 | Receive-check strobe |
| rx_msg | output | MSG_W | Message index for the receive-check strobe |
| ref_req | output | 1 | Reference message request strobe |
| watch_to | output | 1 | Watch timeout strobe |

## Verification
Every strobe is due exactly one clock after the edge at which the block sampled the matching `cycle_time` (or the falling edge of the event pin). A second entry with the same mark is one clock later still. The bench holds each cycle time value for two clocks. It changes inputs just after a rising edge and reads outputs just after the next one. It computes the expected strobe from the table for that cycle time and for the position within the group of entries that share the mark. The sweep covers cycle counts, synchronization, mastership and four gap modes. Directed runs then place event-pin edges and cycle restarts at chosen cycle times and check the strobe in the following clock.

// File: rtl/tts_pkg.sv
package tts_pkg;
  typedef enum logic [2:0] {
    FN_TX        = 3'd0,
    FN_RX        = 3'd1,
    FN_REF       = 3'd2,
    FN_WATCH     = 3'd3,
    FN_REF_GAP   = 3'd4,
    FN_WATCH_GAP = 3'd5
  } tts_fn_e;

  localparam int NUM_FN = 6;
endpackage

// File: rtl/tts_walker.sv
module tts_walker #(
  parameter int NUM_TRIG = 8,
  parameter int TIME_W   = 16,
  localparam int IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1,
  localparam int PTR_W   = $clog2(NUM_TRIG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cycle_start,
  input  logic [TIME_W-1:0] cycle_time,
  input  logic [TIME_W-1:0] mark,
  output logic [IDX_W-1:0]  addr,
  output logic              at_mark
);
  logic [PTR_W-1:0] ptr;
  logic             live;
  logic             reached;

  assign live    = ptr < PTR_W'(NUM_TRIG);
  assign reached = live && !cycle_start && (cycle_time >= mark);
  assign at_mark = reached && (cycle_time == mark);
  assign addr    = ptr[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ptr <= '0;
    else if (cycle_start) ptr <= '0;
    else if (reached)    ptr <= ptr + PTR_W'(1);
  end
endmodule

// File: rtl/tts_cycle_sel.sv
module tts_cycle_sel #(
  parameter int CC_W  = 6,
  parameter int REP_W = 3
) (
  input  logic [CC_W-1:0]  cycle_cnt,
  input  logic [CC_W-1:0]  base,
  input  logic [REP_W-1:0] rep,
  output logic             selected
);
  logic [CC_W-1:0] mask;

  assign mask     = ~({CC_W{1'b1}} << rep);
  assign selected = ((cycle_cnt & mask) == base);
endmodule

// File: rtl/tts_gap_ctrl.sv
module tts_gap_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_start,
  input  logic rx_gap,
  input  logic is_master,
  input  logic event_mode,
  input  logic evt_pin,
  input  logic hit_ref,
  input  logic hit_ref_gap,
  output logic gap_sel,
  output logic ref_now
);
  logic in_gap;
  logic ref_done;
  logic evt_q;
  logic evt_fall;
  logic gap_opens;
  logic early_ref;

  assign evt_fall  = evt_q && !evt_pin;
  assign gap_opens = hit_ref && gap_sel && (!event_mode || evt_pin);
  assign early_ref = hit_ref && gap_sel && event_mode && !evt_pin;

  always_comb begin
    ref_now = 1'b0;
    if (is_master && !ref_done && !cycle_start) begin
      if (hit_ref && !gap_sel)       ref_now = 1'b1;
      else if (early_ref)            ref_now = 1'b1;
      else if (hit_ref_gap && gap_sel) ref_now = 1'b1;
      else if (in_gap && evt_fall)   ref_now = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_sel  <= 1'b0;
      in_gap   <= 1'b0;
      ref_done <= 1'b0;
      evt_q    <= 1'b0;
    end else begin
      evt_q <= evt_pin;
      if (cycle_start) begin
        gap_sel  <= rx_gap;
        in_gap   <= 1'b0;
        ref_done <= 1'b0;
      end else begin
        if (ref_now)        ref_done <= 1'b1;
        if (ref_now)        in_gap   <= 1'b0;
        else if (gap_opens) in_gap   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tt_sched_organizer.sv
module tt_sched_organizer
  import tts_pkg::*;
#(
  parameter int NUM_TRIG = 8,
  parameter int TIME_W   = 16,
  parameter int CC_W     = 6,
  parameter int MSG_W    = 4,
  parameter int REP_W    = 3,
  localparam int IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] cycle_time,
  input  logic [CC_W-1:0]   cycle_cnt,
  input  logic              cycle_start,
  input  logic              sync_ok,
  input  logic              is_master,
  input  logic              rx_gap,
  input  logic              event_mode,
  input  logic              evt_pin,
  output logic [IDX_W-1:0]  tm_addr,
  input  logic [TIME_W-1:0] tm_mark,
  input  logic [2:0]        tm_func,
  input  logic [MSG_W-1:0]  tm_msg,
  input  logic [CC_W-1:0]   tm_base,
  input  logic [REP_W-1:0]  tm_rep,
  output logic              tx_fire,
  output logic [MSG_W-1:0]  tx_msg,
  output logic              rx_fire,
  output logic [MSG_W-1:0]  rx_msg,
  output logic              ref_req,
  output logic              watch_to
);
  logic              at_mark;
  logic              selected;
  logic              hit;
  logic [NUM_FN-1:0] fn_hit;
  logic              gap_sel;
  logic              ref_now;
  logic              tx_d, rx_d, wd_d;

  tts_walker #(.NUM_TRIG(NUM_TRIG), .TIME_W(TIME_W)) u_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cycle_start(cycle_start),
    .cycle_time (cycle_time),
    .mark       (tm_mark),
    .addr       (tm_addr),
    .at_mark    (at_mark)
  );

  tts_cycle_sel #(.CC_W(CC_W), .REP_W(REP_W)) u_sel (
    .cycle_cnt(cycle_cnt),
    .base     (tm_base),
    .rep      (tm_rep),
    .selected (selected)
  );

  assign hit = at_mark && selected;

  for (genvar f = 0; f < NUM_FN; f++) begin : g_fn
    assign fn_hit[f] = hit && (tm_func == 3'(f));
  end

  tts_gap_ctrl u_gap (
    .clk        (clk),
    .rst_n      (rst_n),
    .cycle_start(cycle_start),
    .rx_gap     (rx_gap),
    .is_master  (is_master),
    .event_mode (event_mode),
    .evt_pin    (evt_pin),
    .hit_ref    (fn_hit[FN_REF]),
    .hit_ref_gap(fn_hit[FN_REF_GAP]),
    .gap_sel    (gap_sel),
    .ref_now    (ref_now)
  );

  assign tx_d = fn_hit[FN_TX] && sync_ok;
  assign rx_d = fn_hit[FN_RX];
  assign wd_d = (fn_hit[FN_WATCH] && !gap_sel) ||
                (fn_hit[FN_WATCH_GAP] && gap_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_fire  <= 1'b0;
      rx_fire  <= 1'b0;
      ref_req  <= 1'b0;
      watch_to <= 1'b0;
      tx_msg   <= '0;
      rx_msg   <= '0;
    end else begin
      tx_fire  <= tx_d;
      rx_fire  <= rx_d;
      ref_req  <= ref_now;
      watch_to <= wd_d;
      if (tx_d) tx_msg <= tm_msg;
      if (rx_d) rx_msg <= tm_msg;
    end
  end
endmodule

// File: rtl/tts_chk.sv
module tts_chk (
  input logic clk,
  input logic rst_n,
  input logic cycle_start,
  input logic sync_ok,
  input logic is_master,
  input logic tx_fire,
  input logic rx_fire,
  input logic ref_req,
  input logic watch_to
);
  // R4
  tx_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fire |-> $past(sync_ok));

  // R5
  ref_needs_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> $past(is_master));

  // R8
  single_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |=> !ref_req);

  // R2
  one_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_fire, rx_fire, watch_to}));

  // R10
  start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> !(tx_fire || rx_fire || watch_to));
endmodule

bind tt_sched_organizer tts_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cycle_start(cycle_start),
  .sync_ok    (sync_ok),
  .is_master  (is_master),
  .tx_fire    (tx_fire),
  .rx_fire    (rx_fire),
  .ref_req    (ref_req),
  .watch_to   (watch_to)
);

// File: tb/tb_tt_sched_organizer.sv
module tb_tt_sched_organizer;
  localparam int NT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cycle_time = '0;
  logic [5:0]  cycle_cnt = '0;
  logic        cycle_start = 1'b0;
  logic        sync_ok = 1'b0, is_master = 1'b0, rx_gap = 1'b0;
  logic        event_mode = 1'b0, evt_pin = 1'b0;
  logic [2:0]  tm_addr;
  logic [15:0] tm_mark;
  logic [2:0]  tm_func;
  logic [3:0]  tm_msg;
  logic [5:0]  tm_base;
  logic [2:0]  tm_rep;
  logic        tx_fire, rx_fire, ref_req, watch_to;
  logic [3:0]  tx_msg, rx_msg;

  int m_mark [NT] = '{2, 4, 4, 6, 8, 10, 12, 14};
  int m_func [NT] = '{0, 0, 1, 1, 2, 4, 3, 5};
  int m_msg  [NT] = '{1, 2, 3, 4, 0, 0, 0, 0};
  int m_base [NT] = '{0, 1, 0, 3, 0, 0, 0, 0};
  int m_rep  [NT] = '{0, 1, 1, 2, 0, 0, 0, 0};

  assign tm_mark = 16'(m_mark[tm_addr]);
  assign tm_func = 3'(m_func[tm_addr]);
  assign tm_msg  = 4'(m_msg[tm_addr]);
  assign tm_base = 6'(m_base[tm_addr]);
  assign tm_rep  = 3'(m_rep[tm_addr]);

  tt_sched_organizer dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int seen_ref, seen_wd, seen_tx;
  logic e_tx, e_rx, e_ref, e_wd;
  int   e_txm, e_rxm;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at ct %0d", req, act, exp, cycle_time);
    end
  endtask

  task automatic model(input int ct, input int j);
    int k = 0;
    e_tx = 0; e_rx = 0; e_ref = 0; e_wd = 0; e_txm = 0; e_rxm = 0;
    for (int i = 0; i < NT; i++) begin
      if (m_mark[i] == ct) begin
        if (k == j && ((int'(cycle_cnt) % (1 << m_rep[i])) == m_base[i])) begin
          case (m_func[i])
            0: begin e_tx = sync_ok; e_txm = m_msg[i]; end
            1: begin e_rx = 1; e_rxm = m_msg[i]; end
            2: e_ref = is_master && (!rx_gap || (event_mode && !evt_pin));
            3: e_wd = !rx_gap;
            4: e_ref = is_master && rx_gap && !(event_mode && !evt_pin);
            5: e_wd = rx_gap;
            default: ;
          endcase
        end
        k++;
      end
    end
  endtask

  task automatic start_cycle();
    cycle_start = 1'b1;
    cycle_time  = '0;
    step();
    cycle_start = 1'b0;
  endtask

  task automatic walk(input int a, input int b, input bit do_chk);
    for (int ct = a; ct <= b; ct++) begin
      for (int j = 0; j < 2; j++) begin
        cycle_time = 16'(ct);
        step();
        if (ref_req)  seen_ref = ct;
        if (watch_to) seen_wd  = ct;
        if (tx_fire)  seen_tx  = ct;
        if (do_chk) begin
          model(ct, j);
          chk({tx_fire, rx_fire, ref_req, watch_to} == {e_tx, e_rx, e_ref, e_wd},
              "R2/R3/R4/R5/R6/R7/R9 strobes",
              {tx_fire, rx_fire, ref_req, watch_to}, {e_tx, e_rx, e_ref, e_wd});
          if (e_tx) chk(int'(tx_msg) == e_txm, "R2 tx index", tx_msg, e_txm);
          if (e_rx) chk(int'(rx_msg) == e_rxm, "R3 rx index", rx_msg, e_rxm);
        end
      end
    end
  endtask

  task automatic clear_seen();
    seen_ref = -1; seen_wd = -1; seen_tx = -1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk({tx_fire, rx_fire, ref_req, watch_to} == 4'b0, "R1 strobes", {tx_fire, rx_fire, ref_req, watch_to}, 0);
    chk(tm_addr == 3'd0, "R1 address", tm_addr, 0);
    rst_n = 1'b1;
    step();

    // sweep: cycle count x sync x master x gap mode
    for (int cc = 0; cc < 4; cc++)
      for (int s = 0; s < 2; s++)
        for (int m = 0; m < 2; m++)
          for (int md = 0; md < 4; md++) begin
            cycle_cnt  = 6'(cc);
            sync_ok    = s[0];
            is_master  = m[0];
            rx_gap     = (md != 0);
            event_mode = (md >= 2);
            evt_pin    = (md == 3);
            start_cycle();
            walk(0, 15, 1'b1);
          end

    // R8 falling edge inside a gap requests the reference early
    cycle_cnt = 0; sync_ok = 1; is_master = 1; rx_gap = 1; event_mode = 1; evt_pin = 1;
    start_cycle();
    walk(0, 9, 1'b0);
    evt_pin = 1'b0;
    step();
    chk(ref_req == 1'b1, "R8 early reference", ref_req, 1);
    clear_seen();
    walk(10, 15, 1'b0);
    chk(seen_ref == -1, "R8 one reference per cycle", seen_ref, -1);

    // R8 falling edge before the gap is ignored, R7 low pin at reference mark
    evt_pin = 1'b1;
    start_cycle();
    walk(0, 5, 1'b0);
    evt_pin = 1'b0;
    step();
    chk(ref_req == 1'b0, "R8 edge outside gap ignored", ref_req, 0);
    clear_seen();
    walk(6, 15, 1'b0);
    chk(seen_ref == 8, "R7 no gap when pin low", seen_ref, 8);

    // R9 host gap without edge: gap reference issues request
    event_mode = 0; evt_pin = 0;
    start_cycle();
    clear_seen();
    walk(0, 15, 1'b0);
    chk(seen_ref == 10, "R9 gap reference mark", seen_ref, 10);
    chk(seen_wd == 14, "R6 gap watch mark", seen_wd, 14);

    // R10 restart before watch mark prevents timeout and resets the pointer
    rx_gap = 0;
    start_cycle();
    clear_seen();
    walk(0, 11, 1'b0);
    start_cycle();
    chk(seen_wd == -1, "R10 no watch before restart", seen_wd, -1);
    clear_seen();
    walk(0, 3, 1'b0);
    chk(seen_tx == 2, "R10 pointer back to entry 0", seen_tx, 2);
    walk(4, 13, 1'b0);
    chk(seen_wd == 12, "R6 normal watch mark", seen_wd, 12);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule